// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the memory-mapped control and status face of an SPI master. A host issues 32-bit word reads and writes on a simple strobe bus; the register index is the byte address shifted right by two, so the two low address bits are disregarded. The block holds a transmit word FIFO and a receive word FIFO. It keeps the status flags current from their fill levels and drives one level interrupt and one active-low chip-select per channel.

The bit-level shifting engine sits outside this block. The front end offers the head transmit word to that engine and removes a word when the engine pops it. It pulses a start strobe and presents a burst length. It takes back received words and a completion strobe. Reads of the receive data register pop the receive FIFO. Two status bits are write-one-to-clear. Writing the control register with its enable bit low returns the whole register set and both FIFOs to the reset state.

Register indices: 0 receive data, 1 transmit data, 2 control, 3 configuration, 4 interrupt enable, 5 status, 6 period, 7 test, 8 message data. Control fields: bit 0 enable, bit 1 go, bits 7:4 per-channel master mask, bits 9:8 channel select, bits 23:12 burst length minus one. Status bits: 0 transmit empty, 1 transmit at or below half full, 2 transmit full, 3 receive ready, 4 receive full, 6 receive overflow, 7 transfer complete; all others read 0.

Top module: `spi_regif`

## Requirements
- R1: The register index is bus_addr[11:2]. A write to an index of 9 or above changes nothing, and a read of such an index returns 0.
- R2: Reading index 0 returns 0 while enable is clear and 0xDEADBEEF when the receive FIFO is empty. Otherwise it returns the oldest receive word and removes it.
- R3: Reads of index 1 and index 8 return 0, and a write to index 0 has no effect.
- R4: A write to index 1 or index 8 is pushed into the transmit FIFO unless enable is clear or the FIFO already holds 8 words, in which case it is dropped.
- R5: Writing 1 to status bit 6 or bit 7 clears it; writing 0 leaves it. Bit 6 sets when the engine delivers a word while the receive FIFO is full, and that word is dropped. Bit 7 sets on eng_done. A set event wins over a clear in the same cycle.
- R6: A control write with bit 0 low clears every register and both FIFOs, and the status register then reads 0x00000003. Out of reset the block is in this same state.
- R7: Status bits 0 to 4 track the FIFO levels every cycle as listed above, with bit 1 set while the transmit FIFO holds 4 or fewer words.
- R8: irq is high exactly when status[7:0] AND interrupt-enable[7:0] is nonzero.
- R9: When enable is set and the master mask bit of the selected channel is set, only cs_n[select] is low. Otherwise all cs_n lines are high.
- R10: A control write that sets go (previously clear) with enable set and the selected channel master pulses eng_start for one cycle, the cycle after the write. eng_burst_len is the length field plus one. eng_done clears go unless a control write happens in the same cycle.
- R11: Indices 3, 4, 6 and 7 are plain 32-bit read/write storage.
- R12: tx_avail is high while the transmit FIFO is non-empty, and tx_word shows its oldest word. tx_pop removes that word and has no effect on an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid in the same cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read |
| irq | output | 1 | Level interrupt |
| cs_n | output | 4 | Active-low chip selects |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_burst_len | output | 13 | Burst length in bits |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_word | output | 32 | Oldest transmit word |
| tx_pop | input | 1 | Engine takes the transmit head |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | 32 | Received word |
| eng_done | input | 1 | Transfer complete event |

## Verification
Two pairs of events can fall in the same cycle. In the first, a host read pops the receive FIFO while the engine pushes into it. In the second, a write-one-to-clear of a status bit coincides with the event that sets that bit. The bench drives each pair in one cycle: an engine push against a full FIFO together with a data read, and eng_done together with a clear of bit 7. A transmit push is also made to race an engine pop on a full transmit FIFO. A behavioural queue model predicts the surviving words, the overflow bit and the status value, and these are compared on every clock.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

   localparam int NUM_REGS = 9;

   typedef enum logic [3:0] {
      RI_RXD  = 4'd0,
      RI_TXD  = 4'd1,
      RI_CTRL = 4'd2,
      RI_CFG  = 4'd3,
      RI_IEN  = 4'd4,
      RI_STAT = 4'd5,
      RI_PER  = 4'd6,
      RI_TEST = 4'd7,
      RI_MSG  = 4'd8
   } reg_idx_e;

   // control field positions
   localparam int CT_EN       = 0;
   localparam int CT_GO       = 1;
   localparam int CT_MODE_LSB = 4;
   localparam int CT_SEL_LSB  = 8;
   localparam int CT_LEN_LSB  = 12;

   // status bit positions
   localparam int ST_TE  = 0;
   localparam int ST_TDR = 1;
   localparam int ST_TF  = 2;
   localparam int ST_RR  = 3;
   localparam int ST_RF  = 4;
   localparam int ST_RO  = 6;
   localparam int ST_TC  = 7;

   localparam logic [31:0] EMPTY_READ = 32'hDEAD_BEEF;

endpackage

// File: rtl/spi_regif_fifo.sv
module spi_regif_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_regif_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_regif_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = mem[rp];
   assign count   = cnt;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= nxt(wp);
         if (do_pop)  rp <= nxt(rp);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   // level never exceeds the depth (R7)
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // a push into a full FIFO without a pop leaves it full and unchanged in level (R4)
   p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && $stable(cnt)));

endmodule

// File: rtl/spi_regif_csdec.sv
module spi_regif_csdec #(
   parameter int NUM_CS = 4
) (
   input  logic                        en,
   input  logic [NUM_CS-1:0]           mode,
   input  logic [$clog2(NUM_CS)-1:0]   sel,
   output logic [NUM_CS-1:0]           cs_n
);
   localparam int SEL_W = $clog2(NUM_CS);

   logic active;
   assign active = en & mode[sel];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      assign cs_n[i] = ~(active && (sel == SEL_W'(i)));
   end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
   import spi_regif_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int ADDR_W     = 12,
   parameter int LEN_W      = 12,
   parameter int NUM_CS     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                irq,
   output logic [NUM_CS-1:0]   cs_n,
   output logic                eng_start,
   output logic [LEN_W:0]      eng_burst_len,
   output logic                tx_avail,
   output logic [31:0]         tx_word,
   input  logic                tx_pop,
   input  logic                rx_push,
   input  logic [31:0]         rx_word,
   input  logic                eng_done
);
   localparam int IDX_W  = ADDR_W - 2;
   localparam int SEL_W  = $clog2(NUM_CS);
   localparam int CW     = $clog2(FIFO_DEPTH + 1);
   localparam int HALF   = FIFO_DEPTH / 2;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("spi_regif: ADDR_W must cover all register indices");
   end
   if (NUM_CS != 2 && NUM_CS != 4) begin : g_bad_cs
      $error("spi_regif: NUM_CS must be 2 or 4");
   end
   if (LEN_W < 1 || LEN_W > 32 - CT_LEN_LSB) begin : g_bad_len
      $error("spi_regif: LEN_W does not fit the control word");
   end

   // ---------------- address decode ----------------
   logic [IDX_W-1:0] idx;
   logic             in_rng;
   reg_idx_e         ridx;

   assign idx    = bus_addr[ADDR_W-1:2];
   assign in_rng = (idx < IDX_W'(NUM_REGS));
   assign ridx   = reg_idx_e'(idx[3:0]);

   logic wr_ctrl, wr_cfg, wr_ien, wr_stat, wr_per, wr_test, wr_tx, rd_rx;
   assign wr_ctrl = bus_wr & in_rng & (ridx == RI_CTRL);
   assign wr_cfg  = bus_wr & in_rng & (ridx == RI_CFG);
   assign wr_ien  = bus_wr & in_rng & (ridx == RI_IEN);
   assign wr_stat = bus_wr & in_rng & (ridx == RI_STAT);
   assign wr_per  = bus_wr & in_rng & (ridx == RI_PER);
   assign wr_test = bus_wr & in_rng & (ridx == RI_TEST);
   assign wr_tx   = bus_wr & in_rng & ((ridx == RI_TXD) | (ridx == RI_MSG));
   assign rd_rx   = bus_rd & in_rng & (ridx == RI_RXD);

   // ---------------- register state ----------------
   logic [31:0] ctrl_q, cfg_q, ien_q, per_q, test_q;
   logic        ovf_q, tc_q, start_q;
   logic        en, dis_rst;

   assign en      = ctrl_q[CT_EN];
   assign dis_rst = wr_ctrl & ~bus_wdata[CT_EN];

   // ---------------- FIFOs ----------------
   logic          tx_empty, tx_full, rx_empty, rx_full;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic [31:0]   rx_head;
   logic          rx_pop, ovf_evt;

   assign rx_pop  = rd_rx & en & ~rx_empty;
   assign ovf_evt = rx_push & rx_full & ~dis_rst;

   spi_regif_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (dis_rst),
      .push  (wr_tx & en),
      .din   (bus_wdata),
      .pop   (tx_pop),
      .dout  (tx_word),
      .empty (tx_empty),
      .full  (tx_full),
      .count (tx_cnt)
   );

   spi_regif_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (dis_rst),
      .push  (rx_push),
      .din   (rx_word),
      .pop   (rx_pop),
      .dout  (rx_head),
      .empty (rx_empty),
      .full  (rx_full),
      .count (rx_cnt)
   );

   // ---------------- start request ----------------
   logic [NUM_CS-1:0] w_mode;
   logic [SEL_W-1:0]  w_sel;
   logic              go_req;

   assign w_mode = bus_wdata[CT_MODE_LSB +: NUM_CS];
   assign w_sel  = bus_wdata[CT_SEL_LSB +: SEL_W];
   assign go_req = wr_ctrl & bus_wdata[CT_EN] & bus_wdata[CT_GO]
                 & ~ctrl_q[CT_GO] & w_mode[w_sel];

   always_ff @(posedge clk) begin
      if (!rst_n || dis_rst) begin
         ctrl_q  <= '0;
         cfg_q   <= '0;
         ien_q   <= '0;
         per_q   <= '0;
         test_q  <= '0;
         ovf_q   <= 1'b0;
         tc_q    <= 1'b0;
         start_q <= 1'b0;
      end else begin
         if (wr_ctrl)       ctrl_q        <= bus_wdata;
         else if (eng_done) ctrl_q[CT_GO] <= 1'b0;
         if (wr_cfg)  cfg_q  <= bus_wdata;
         if (wr_ien)  ien_q  <= bus_wdata;
         if (wr_per)  per_q  <= bus_wdata;
         if (wr_test) test_q <= bus_wdata;
         ovf_q   <= (ovf_q & ~(wr_stat & bus_wdata[ST_RO])) | ovf_evt;
         tc_q    <= (tc_q  & ~(wr_stat & bus_wdata[ST_TC])) | eng_done;
         start_q <= go_req;
      end
   end

   // ---------------- status and interrupt ----------------
   logic [31:0] status;
   always_comb begin
      status         = '0;
      status[ST_TE]  = tx_empty;
      status[ST_TDR] = (tx_cnt <= CW'(HALF));
      status[ST_TF]  = tx_full;
      status[ST_RR]  = ~rx_empty;
      status[ST_RF]  = rx_full;
      status[ST_RO]  = ovf_q;
      status[ST_TC]  = tc_q;
   end

   assign irq = |(status[7:0] & ien_q[7:0]);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && in_rng) begin
         case (ridx)
            RI_RXD:  bus_rdata = !en ? 32'h0 : (rx_empty ? EMPTY_READ : rx_head);
            RI_CTRL: bus_rdata = ctrl_q;
            RI_CFG:  bus_rdata = cfg_q;
            RI_IEN:  bus_rdata = ien_q;
            RI_STAT: bus_rdata = status;
            RI_PER:  bus_rdata = per_q;
            RI_TEST: bus_rdata = test_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   // ---------------- engine side and chip selects ----------------
   assign eng_start     = start_q;
   assign eng_burst_len = {1'b0, ctrl_q[CT_LEN_LSB +: LEN_W]} + (LEN_W+1)'(1);
   assign tx_avail      = ~tx_empty;

   spi_regif_csdec #(.NUM_CS(NUM_CS)) u_cs (
      .en   (en),
      .mode (ctrl_q[CT_MODE_LSB +: NUM_CS]),
      .sel  (ctrl_q[CT_SEL_LSB +: SEL_W]),
      .cs_n (cs_n)
   );

   // ---------------- assertions ----------------
   p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_rst |=> (status == 32'h3 && ctrl_q == '0 && !tx_avail && !irq));

   p_w1c_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && bus_wdata[ST_RO] && !ovf_evt) |=> !ovf_q);

   p_tc_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !dis_rst) |=> tc_q);

   p_tx_drop_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx && !en && !tx_pop) |=> $stable(tx_cnt));

   p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);

   p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (&cs_n));

endmodule

// File: tb/spi_regif_tb.sv
module spi_regif_tb;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr, bus_rd;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        irq;
   logic [3:0]  cs_n;
   logic        eng_start;
   logic [12:0] eng_burst_len;
   logic        tx_avail;
   logic [31:0] tx_word;
   logic        tx_pop, rx_push, eng_done;
   logic [31:0] rx_word;

   always #5 clk = ~clk;

   spi_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .cs_n(cs_n), .eng_start(eng_start),
      .eng_burst_len(eng_burst_len), .tx_avail(tx_avail), .tx_word(tx_word),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
      .eng_done(eng_done)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_ctrl, m_cfg, m_ien, m_per, m_test;
   bit          m_ovf, m_tc, m_start;
   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   int          n_cmp = 0, n_bad = 0;
   string       req = "R6";
   bit          finished = 0;

   function automatic void m_clear();
      m_ctrl = 0; m_cfg = 0; m_ien = 0; m_per = 0; m_test = 0;
      m_ovf = 0; m_tc = 0; m_start = 0;
      txq.delete(); rxq.delete();
   endfunction

   function automatic logic [31:0] m_status();
      logic [31:0] s = '0;
      s[0] = (txq.size() == 0);
      s[1] = (txq.size() <= DEPTH/2);
      s[2] = (txq.size() == DEPTH);
      s[3] = (rxq.size() != 0);
      s[4] = (rxq.size() == DEPTH);
      s[6] = m_ovf;
      s[7] = m_tc;
      return s;
   endfunction

   function automatic logic [31:0] m_rdata();
      int idx = int'(bus_addr[11:2]);
      if (!bus_rd || idx >= 9) return 0;
      case (idx)
         0: return !m_ctrl[0] ? 32'h0 : (rxq.size() == 0 ? 32'hDEADBEEF : rxq[0]);
         2: return m_ctrl;
         3: return m_cfg;
         4: return m_ien;
         5: return m_status();
         6: return m_per;
         7: return m_test;
         default: return 0;
      endcase
   endfunction

   function automatic logic [3:0] m_cs();
      int sel = int'(m_ctrl[9:8]);
      if (m_ctrl[0] && m_ctrl[4+sel]) return ~(4'b1 << sel);
      return 4'hF;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s): actual %h expected %h", tag, req, act, exp);
      end
   endtask

   task automatic m_update();
      int  idx = int'(bus_addr[11:2]);
      bit  inr = (idx < 9);
      bit  en  = m_ctrl[0];
      int  txn = txq.size();
      int  rxn = rxq.size();
      bit  ovf_evt = 0;
      bit  wr_ctrl = bus_wr && inr && idx == 2;
      bit  go;
      if (wr_ctrl && !bus_wdata[0]) begin
         m_clear();
         return;
      end
      go = wr_ctrl && bus_wdata[0] && bus_wdata[1] && !m_ctrl[1]
           && bus_wdata[4 + int'(bus_wdata[9:8])];
      if (bus_rd && inr && idx == 0 && en && rxn > 0) void'(rxq.pop_front());
      if (rx_push) begin
         if (rxn == DEPTH) ovf_evt = 1;
         else rxq.push_back(rx_word);
      end
      if (tx_pop && txn > 0) void'(txq.pop_front());
      if (bus_wr && inr && (idx == 1 || idx == 8) && en && txn < DEPTH)
         txq.push_back(bus_wdata);
      if (bus_wr && inr && idx == 5) begin
         if (bus_wdata[6]) m_ovf = 0;
         if (bus_wdata[7]) m_tc = 0;
      end
      if (ovf_evt) m_ovf = 1;
      if (eng_done) m_tc = 1;
      if (wr_ctrl) m_ctrl = bus_wdata;
      else if (eng_done) m_ctrl[1] = 0;
      if (bus_wr && inr && idx == 3) m_cfg  = bus_wdata;
      if (bus_wr && inr && idx == 4) m_ien  = bus_wdata;
      if (bus_wr && inr && idx == 6) m_per  = bus_wdata;
      if (bus_wr && inr && idx == 7) m_test = bus_wdata;
      m_start = go;
   endtask

   task automatic idle();
      bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
      tx_pop = 0; rx_push = 0; rx_word = 0; eng_done = 0;
   endtask

   // one clock: compare all outputs, advance the model, then idle inputs
   task automatic cycle();
      logic [31:0] st;
      #1;
      st = m_status();
      chk("R8 irq", {31'b0, irq}, {31'b0, |(st[7:0] & m_ien[7:0])});
      chk("R9 cs_n", {28'b0, cs_n}, {28'b0, m_cs()});
      chk("R12 tx_avail", {31'b0, tx_avail}, {31'b0, txq.size() != 0});
      if (txq.size() != 0) chk("R12 tx_word", tx_word, txq[0]);
      chk("R10 eng_start", {31'b0, eng_start}, {31'b0, m_start});
      chk("R10 burst_len", {19'b0, eng_burst_len}, {19'b0, 13'({1'b0, m_ctrl[23:12]}) + 13'd1});
      if (bus_rd) chk("rdata", bus_rdata, m_rdata());
      @(posedge clk);
      m_update();
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      bus_wr = 1; bus_addr = 12'(a); bus_wdata = d; cycle();
   endtask

   task automatic rd(input int a);
      bus_rd = 1; bus_addr = 12'(a); cycle();
   endtask

   localparam logic [31:0] CTRL_ON = 32'h0001_F241; // en, ch2 master, sel 2, len 32

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 0;
      m_clear();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R6 reset state
      req = "R6 reset state";
      bus_rd = 1; bus_addr = 12'd20; #1;
      chk("R6 status after reset", bus_rdata, 32'h3);
      cycle();

      // R1 decode
      req = "R1 out of range";
      wr(12 << 2, 32'hFFFF_FFFF);
      rd(12 << 2);
      rd(9 << 2);
      req = "R1 low bits ignored";
      wr(3*4 + 2, 32'hA5A5_0001);
      rd(3*4);

      // R11 storage
      req = "R11 storage";
      wr(6*4, 32'h1234_5678);
      wr(7*4, 32'hCAFE_0007);
      wr(4*4, 32'h0000_0100);
      rd(6*4); rd(7*4); rd(4*4);
      wr(4*4, 32'h0);

      // R4 dropped while disabled, R2 read while disabled
      req = "R4 disabled drop";
      wr(4, 32'h1111_1111);
      wr(32, 32'h2222_2222);
      req = "R2 disabled read";
      rx_push = 1; rx_word = 32'h55; rd(0);

      // R9 chip selects
      req = "R9 select master";
      wr(8, CTRL_ON);
      rd(8);
      req = "R9 select non-master";
      wr(8, (CTRL_ON & ~32'h300) | 32'h100);
      wr(8, CTRL_ON);

      // R4 pushes, ninth dropped
      req = "R4 fill tx";
      for (int i = 0; i < 9; i++) wr((i % 2) ? 32 : 4, 32'hA000_0000 + i);
      req = "R7 tx full flags";
      rd(20);
      req = "R3 tx and msg read zero";
      rd(4); rd(32);
      req = "R3 rx data write ignored";
      wr(0, 32'hBAD0_BAD0);
      rd(20);

      // R12 pop races a push on a full FIFO
      req = "R12 pop with push on full";
      tx_pop = 1; wr(4, 32'hB000_0001);
      req = "R12 pop with push";
      tx_pop = 1; wr(32, 32'hB000_0002);
      for (int i = 0; i < 3; i++) begin tx_pop = 1; cycle(); end
      req = "R7 tx mid level";
      rd(20);

      // R2 / R5 receive path and overflow
      req = "R5 rx fill and overflow";
      for (int i = 0; i < 9; i++) begin rx_push = 1; rx_word = 32'hC000_0000 + i; cycle(); end
      rd(20);
      req = "R2 pop races push on full";
      rx_push = 1; rx_word = 32'hD000_0001; rd(0);
      req = "R2 pop with push";
      rx_push = 1; rx_word = 32'hD000_0002; rd(0);
      req = "R2 drain";
      for (int i = 0; i < 8; i++) rd(0);
      req = "R2 empty read";
      rd(0);
      rd(20);

      // R5 write-one-to-clear
      req = "R5 clear overflow";
      wr(20, 32'h40); rd(20);
      req = "R5 done with clear same cycle";
      eng_done = 1; wr(20, 32'h80); rd(20);
      req = "R5 write zero keeps";
      wr(20, 32'h3F); rd(20);
      req = "R5 clear complete";
      wr(20, 32'h80); rd(20);

      // R8 interrupt
      req = "R8 irq enable";
      wr(16, 32'h80);
      eng_done = 1; cycle();
      wr(20, 32'h80);
      wr(16, 32'h1);
      wr(16, 32'h0);

      // R10 start strobe
      req = "R10 go pulse";
      wr(8, CTRL_ON | 32'h2);
      cycle();
      wr(8, CTRL_ON | 32'h2);
      eng_done = 1; cycle();
      rd(8);
      req = "R10 go non-master no pulse";
      wr(8, (CTRL_ON & ~32'h300) | 32'h102);
      cycle();

      // R7 drain tx
      req = "R7 tx drain";
      for (int i = 0; i < 8; i++) begin tx_pop = 1; cycle(); end
      rd(20);

      // R6 disable clears everything
      req = "R6 disable reset";
      wr(4, 32'hE000_0001);
      rx_push = 1; rx_word = 32'hE1; cycle();
      wr(16, 32'hFF);
      wr(8, 32'h0);
      rd(20); rd(8); rd(12); rd(16); rd(24); rd(0);
      cycle();

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule